// File: doc/BRIEF.md
# Vector Condition-Field Bit Packer

This block walks a vector of VL four-bit condition fields and reduces each one to a single result bit. The reduction first compares every field bit with a per-bit mode pattern, then keeps only the bits that a mask selects, and finally combines the survivors with OR or with AND. The result bits are packed into integer registers.

A controller loads the configuration with a one-cycle `start` pulse. The engine reads at most one field per cycle through a valid/ready read port. It writes each integer element out through a valid/ready write port when the element is full or the loop reaches its last result. It then raises `done` for one cycle.

The read port follows one rule: a read counts in a cycle where `rd_valid` and `rd_ready` are both high, and the responder must show the field at `rd_idx` on `rd_field` in that same cycle. The write port follows one rule: a write is taken in a cycle where `wr_valid` and `wr_ready` are both high. When the far side holds ready low, the engine stalls with the index and data held steady. The `start` pulse and `done` are plain control pins.

Top module: `cond_field_packer`

## Requirements
- R1: For each result, bit j of the field is matched when it equals bit j of `cfg_mode` (field bit 0 pairs with mask/mode bit 0). A matched bit counts only where bit j of `cfg_mask` is 1. The result is the OR of the four counted bits when `cfg_any`=1, and their AND when `cfg_any`=0.
- R2: Result i reads field `cfg_src_base`+i, modulo the field count, when `cfg_src_vec`=1. It reads field `cfg_src_base` for every i when `cfg_src_vec`=0.
- R3: With `cfg_dst_vec`=0, result i lands at bit i of a single write to register `cfg_dst_base`. That write happens after the last result, and all bits at VL and above are zero.
- R4: With `cfg_dst_vec`=1, the packing factor k is 1, 2, 4 or 8 for `cfg_pack` codes 0, 1, 2 and 3. Result i goes to register `cfg_dst_base`+i/k (modulo the register count) at bit i mod k. Bits k and above of every written register are zero.
- R5: A register that is only partly filled when the last result is produced is still written, and its unfilled bits are zero.
- R6: A start with `cfg_vl`=0 makes `done` high in the next cycle, with no read and no write.
- R7: `done` is high for exactly one cycle, in the cycle right after the final write handshake, and the ports are quiet in that cycle.
- R8: Exactly VL read handshakes occur per run. Read and write requests are never raised in the same cycle. Under back-pressure, a pending request keeps its valid, index and data unchanged.
- R9: During and right after reset, `rd_valid`, `wr_valid` and `done` are low.
- R10: A `start` pulse while a run is in progress is ignored. The configuration latched at the accepted start governs the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; the cfg_* inputs are sampled while idle |
| cfg_vl | input | VL_W | Result count 0..MAX_VL; larger values are clamped |
| cfg_src_base | input | FIDX_W | First condition field index |
| cfg_src_vec | input | 1 | 1: step the field index per result; 0: hold it |
| cfg_dst_base | input | RIDX_W | First integer register index |
| cfg_dst_vec | input | 1 | 1: packed vector destination; 0: one scalar register |
| cfg_pack | input | 2 | Packing code; results per register = 1 << code |
| cfg_mask | input | 4 | Selects which field bits take part |
| cfg_mode | input | 4 | Pattern each field bit is compared with |
| cfg_any | input | 1 | 1: OR reduction; 0: AND reduction |
| rd_valid | output | 1 | Field read request |
| rd_ready | input | 1 | Field read accepted, data present |
| rd_idx | output | FIDX_W | Field index to read |
| rd_field | input | 4 | Field value for rd_idx |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register write accepted |
| wr_idx | output | RIDX_W | Register index to write |
| wr_data | output | XLEN | Packed register value |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The packer is tried with all four packing codes. Run lengths are chosen to fill the last register exactly or to leave it partly full, so a missing flush can be told apart from a wrong bit offset. Scalar and stepping sources are contrasted, including an index run that wraps past the last field and a register run that wraps past the last register. Both reductions are exercised with mask/mode pairs that separate OR from AND, a zero mask, and an inverted mode. Back-pressure on both ports, a zero-length run, and a restart attempt during a run show that the handshake timing and the latched configuration hold.

// File: rtl/crpk_pkg.sv
package crpk_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } crpk_state_e;
endpackage

// File: rtl/crpk_reduce.sv
module crpk_reduce #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] field,
  input  logic [FW-1:0] mask,
  input  logic [FW-1:0] mode,
  input  logic          any,
  output logic          bit_out
);
  logic [FW-1:0] hits;

  always_comb begin
    hits    = mask & ~(field ^ mode);
    bit_out = any ? (|hits) : (&hits);
  end
endmodule

// File: rtl/crpk_seq.sv
module crpk_seq #(
  parameter int VL_W   = 7,
  parameter int FIDX_W = 6,
  parameter int RIDX_W = 5,
  parameter int SLOT_W = 6
) (
  input  logic [VL_W-1:0]   cnt,
  input  logic [VL_W-1:0]   vl,
  input  logic [FIDX_W-1:0] src_base,
  input  logic              src_vec,
  input  logic [RIDX_W-1:0] dst_base,
  input  logic              dst_vec,
  input  logic [1:0]        pack,
  output logic [FIDX_W-1:0] fld_idx,
  output logic [SLOT_W-1:0] slot,
  output logic [RIDX_W-1:0] reg_idx,
  output logic              elem_full,
  output logic              elem_last
);
  logic [VL_W-1:0] kmask;
  logic [VL_W-1:0] in_elem;

  always_comb begin
    kmask     = (VL_W'(1) << pack) - VL_W'(1);
    in_elem   = cnt & kmask;
    fld_idx   = src_vec ? src_base + FIDX_W'(cnt) : src_base;
    slot      = dst_vec ? SLOT_W'(in_elem) : SLOT_W'(cnt);
    reg_idx   = dst_vec ? dst_base + RIDX_W'(cnt >> pack) : dst_base;
    elem_full = dst_vec && (in_elem == kmask);
    elem_last = (cnt == vl - VL_W'(1));
  end
endmodule

// File: rtl/crpk_accum.sv
module crpk_accum #(
  parameter int XLEN   = 64,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ins,
  input  logic [SLOT_W-1:0] slot,
  input  logic              bit_in,
  output logic [XLEN-1:0]   acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (ins)      acc <= acc | (XLEN'(bit_in) << slot);
  end
endmodule

// File: rtl/cond_field_packer.sv
module cond_field_packer #(
  parameter int NUM_FIELDS = 64,
  parameter int NUM_REGS   = 32,
  parameter int XLEN       = 64,
  parameter int MAX_VL     = 64,
  // derived widths, not meant to be overridden
  parameter int FIDX_W     = $clog2(NUM_FIELDS),
  parameter int RIDX_W     = $clog2(NUM_REGS),
  parameter int VL_W       = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   cfg_vl,
  input  logic [FIDX_W-1:0] cfg_src_base,
  input  logic              cfg_src_vec,
  input  logic [RIDX_W-1:0] cfg_dst_base,
  input  logic              cfg_dst_vec,
  input  logic [1:0]        cfg_pack,
  input  logic [3:0]        cfg_mask,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_any,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [FIDX_W-1:0] rd_idx,
  input  logic [3:0]        rd_field,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              done
);
  import crpk_pkg::*;

  localparam int SLOT_W = $clog2(XLEN);
  localparam int FW     = FIELD_W;

  crpk_state_e       st;
  logic [VL_W-1:0]   cnt, vl_q;
  logic [FIDX_W-1:0] src_base_q;
  logic [RIDX_W-1:0] dst_base_q, widx_q;
  logic              src_vec_q, dst_vec_q, any_q, last_q;
  logic [1:0]        pack_q;
  logic [FW-1:0]     mask_q, mode_q;
  logic [VL_W-1:0]   vl_lim;

  logic [SLOT_W-1:0] slot;
  logic [RIDX_W-1:0] reg_idx;
  logic              elem_full, elem_last, res_bit;
  logic              rd_fire, wr_fire, acc_clr;
  logic [XLEN-1:0]   acc;

  crpk_seq #(.VL_W(VL_W), .FIDX_W(FIDX_W), .RIDX_W(RIDX_W), .SLOT_W(SLOT_W)) u_seq (
    .cnt(cnt), .vl(vl_q), .src_base(src_base_q), .src_vec(src_vec_q),
    .dst_base(dst_base_q), .dst_vec(dst_vec_q), .pack(pack_q),
    .fld_idx(rd_idx), .slot(slot), .reg_idx(reg_idx),
    .elem_full(elem_full), .elem_last(elem_last)
  );

  crpk_reduce #(.FW(FW)) u_red (
    .field(rd_field), .mask(mask_q), .mode(mode_q), .any(any_q), .bit_out(res_bit)
  );

  crpk_accum #(.XLEN(XLEN), .SLOT_W(SLOT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .ins(rd_fire),
    .slot(slot), .bit_in(res_bit), .acc(acc)
  );

  always_comb begin
    rd_valid = (st == ST_READ);
    wr_valid = (st == ST_WRITE);
    done     = (st == ST_DONE);
    rd_fire  = rd_valid && rd_ready;
    wr_fire  = wr_valid && wr_ready;
    acc_clr  = ((st == ST_IDLE) && start) || wr_fire;
    wr_idx   = widx_q;
    wr_data  = acc;
    vl_lim   = (cfg_vl > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : cfg_vl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      vl_q       <= '0;
      src_base_q <= '0;
      dst_base_q <= '0;
      widx_q     <= '0;
      src_vec_q  <= 1'b0;
      dst_vec_q  <= 1'b0;
      any_q      <= 1'b0;
      last_q     <= 1'b0;
      pack_q     <= '0;
      mask_q     <= '0;
      mode_q     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          vl_q       <= vl_lim;
          src_base_q <= cfg_src_base;
          src_vec_q  <= cfg_src_vec;
          dst_base_q <= cfg_dst_base;
          dst_vec_q  <= cfg_dst_vec;
          pack_q     <= cfg_pack;
          mask_q     <= cfg_mask;
          mode_q     <= cfg_mode;
          any_q      <= cfg_any;
          cnt        <= '0;
          st         <= (vl_lim == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: if (rd_fire) begin
          if (elem_full || elem_last) begin
            widx_q <= reg_idx;
            last_q <= elem_last;
            st     <= ST_WRITE;
          end else begin
            cnt <= cnt + VL_W'(1);
          end
        end
        ST_WRITE: if (wr_fire) begin
          if (last_q) begin
            st <= ST_DONE;
          end else begin
            cnt <= cnt + VL_W'(1);
            st  <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crpk_chk.sv
module crpk_chk #(
  parameter int FIDX_W = 6,
  parameter int RIDX_W = 5,
  parameter int XLEN   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [FIDX_W-1:0] rd_idx,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [RIDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]   wr_data,
  input logic              done
);
  // R8
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_idx));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_data));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid && !wr_valid);

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready) || $past(start));
endmodule

bind cond_field_packer crpk_chk #(.FIDX_W(FIDX_W), .RIDX_W(RIDX_W), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
  .done(done)
);

// File: tb/cond_field_packer_bench.sv
`timescale 1ns/1ps
module cond_field_packer_bench;
  typedef struct packed {
    logic [6:0] vl;
    logic [5:0] sb;
    logic       sv;
    logic [4:0] db;
    logic       dv;
    logic [1:0] pk;
    logic [3:0] mask;
    logic [3:0] mode;
    logic       any;
    logic [6:0] nw;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'd1,  6'd3,  1'b1, 5'd2,  1'b0, 2'd0, 4'hF, 4'h5, 1'b0, 7'd1},
    '{7'd10, 6'd60, 1'b1, 5'd30, 1'b1, 2'd0, 4'hC, 4'h4, 1'b1, 7'd10},
    '{7'd9,  6'd0,  1'b1, 5'd4,  1'b1, 2'd1, 4'h5, 4'h1, 1'b0, 7'd5},
    '{7'd13, 6'd7,  1'b1, 5'd8,  1'b1, 2'd2, 4'h3, 4'h2, 1'b1, 7'd4},
    '{7'd20, 6'd11, 1'b1, 5'd12, 1'b1, 2'd3, 4'hF, 4'hA, 1'b0, 7'd3},
    '{7'd64, 6'd0,  1'b1, 5'd1,  1'b0, 2'd2, 4'h9, 4'h1, 1'b1, 7'd1},
    '{7'd7,  6'd5,  1'b0, 5'd20, 1'b1, 2'd3, 4'h6, 4'h6, 1'b0, 7'd1},
    '{7'd16, 6'd30, 1'b1, 5'd31, 1'b1, 2'd3, 4'h0, 4'h0, 1'b1, 7'd2},
    '{7'd40, 6'd20, 1'b1, 5'd9,  1'b0, 2'd0, 4'h6, 4'h6, 1'b0, 7'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] cfg_vl = '0;
  logic [5:0] cfg_src_base = '0;
  logic [4:0] cfg_dst_base = '0;
  logic cfg_src_vec = 1'b0, cfg_dst_vec = 1'b0, cfg_any = 1'b0;
  logic [1:0] cfg_pack = '0;
  logic [3:0] cfg_mask = '0, cfg_mode = '0;
  logic rd_valid, rd_ready = 1'b1, wr_valid, wr_ready = 1'b1, done;
  logic [5:0] rd_idx;
  logic [3:0] rd_field;
  logic [4:0] wr_idx;
  logic [63:0] wr_data;

  always #2 clk = ~clk;

  cond_field_packer u_cond_field_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl),
    .cfg_src_base(cfg_src_base), .cfg_src_vec(cfg_src_vec),
    .cfg_dst_base(cfg_dst_base), .cfg_dst_vec(cfg_dst_vec), .cfg_pack(cfg_pack),
    .cfg_mask(cfg_mask), .cfg_mode(cfg_mode), .cfg_any(cfg_any),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx), .rd_field(rd_field),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done)
  );

  function automatic logic [3:0] fld(input int j);
    return 4'((j * 7) ^ (j >> 3));
  endfunction
  assign rd_field = fld(int'(rd_idx));

  int nchk = 0, nfail = 0, cyc = 0, last_wr_cyc = -10, ngot = 0, nrd = 0, ndone = 0;
  logic [4:0]  got_idx [64];
  logic [63:0] got_dat [64];
  logic [4:0]  exp_idx [64];
  logic [63:0] exp_dat [64];
  int nexp = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready <= stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    wr_ready <= stall_en ? (lfsr[1] & lfsr[6]) | lfsr[2] : 1'b1;
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      if (ngot < 64) begin
        got_idx[ngot] = wr_idx;
        got_dat[ngot] = wr_data;
      end
      ngot = ngot + 1;
      last_wr_cyc = cyc;
    end
    if (rd_valid && rd_ready) nrd = nrd + 1;
    if (done) ndone = ndone + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build_expect(input vec_t v);
    int k;
    logic [3:0] f, n;
    logic b;
    nexp = 0;
    k = 1 << v.pk;
    for (int i = 0; i < int'(v.vl); i++) begin
      f = fld(v.sv ? (int'(v.sb) + i) % 64 : int'(v.sb));
      n = v.mask & ~(f ^ v.mode);
      b = v.any ? |n : &n;
      if (v.dv) begin
        if (i % k == 0) begin
          exp_idx[nexp] = 5'((int'(v.db) + i / k) % 32);
          exp_dat[nexp] = '0;
          nexp++;
        end
        exp_dat[nexp-1][i % k] = b;
      end else begin
        if (i == 0) begin
          exp_idx[0] = v.db;
          exp_dat[0] = '0;
          nexp = 1;
        end
        exp_dat[0][i] = b;
      end
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_vl = v.vl; cfg_src_base = v.sb; cfg_src_vec = v.sv; cfg_dst_base = v.db;
    cfg_dst_vec = v.dv; cfg_pack = v.pk; cfg_mask = v.mask; cfg_mode = v.mode;
    cfg_any = v.any;
  endtask

  task automatic run(input vec_t v, input bit restart_mid, input vec_t alt, input string tag);
    int wd;
    bit seen;
    build_expect(v);
    chk(nexp == int'(v.nw), "R4", {tag, " table write count"}, 64'(nexp), 64'(v.nw));
    @(negedge clk);
    ngot = 0; nrd = 0; ndone = 0;
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wd = 0; seen = 0;
    while (!seen && wd < 3000) begin
      if (restart_mid && wd == 3) begin
        apply(alt);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        seen = 1;
        chk(last_wr_cyc == cyc - 1, "R7", {tag, " done follows final write"},
            64'(last_wr_cyc), 64'(cyc - 1));
      end else begin
        @(negedge clk);
        wd++;
      end
    end
    start = 1'b0;
    chk(seen, "R7", {tag, " watchdog"}, 64'(wd), 64'(0));
    @(negedge clk);
    chk(!done && ndone == 1, "R7", {tag, " done one cycle"}, 64'(ndone), 64'(1));
    chk(nrd == int'(v.vl), "R8", {tag, " read count"}, 64'(nrd), 64'(v.vl));
    chk(ngot == nexp, "R5", {tag, " write count"}, 64'(ngot), 64'(nexp));
    for (int w = 0; w < nexp && w < ngot; w++) begin
      chk(got_idx[w] == exp_idx[w], v.dv ? "R4" : "R3", {tag, " write index"},
          64'(got_idx[w]), 64'(exp_idx[w]));
      chk(got_dat[w] == exp_dat[w], "R1 R2 R5", {tag, " write data"},
          got_dat[w], exp_dat[w]);
    end
  endtask

  initial begin
    vec_t z;
    z = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!rd_valid && !wr_valid && !done, "R9", "outputs in reset",
        64'({rd_valid, wr_valid, done}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done, "R9", "outputs after reset",
        64'({rd_valid, wr_valid, done}), 64'(0));

    // table walk, first without then with back-pressure (R1..R5, R7, R8)
    for (int p = 0; p < 2; p++) begin
      stall_en = (p == 1);
      for (int t = 0; t < NV; t++) run(VECS[t], 1'b0, z, $sformatf("vec%0d/p%0d", t, p));
    end
    stall_en = 1'b0;

    // R10 restart attempt mid-run must be ignored
    run(VECS[3], 1'b1, VECS[4], "R10 restart");

    // R6 zero-length run
    @(negedge clk);
    ngot = 0; nrd = 0; ndone = 0;
    cfg_vl = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R6", "done after zero-length start", 64'(done), 64'(1));
    @(negedge clk);
    chk(!done && ngot == 0 && nrd == 0, "R6", "no traffic on zero-length run",
        64'(ngot + nrd), 64'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule